// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit applies the decimal correction steps that follow binary arithmetic on a pair of byte registers: a low accumulator byte and a high accumulator byte. It handles three operations, picked by a two-bit operation code. The first corrects the result of an unpacked (one digit per byte) addition. The second corrects the result of a packed (two digits per byte) subtraction. The third splits a binary byte into two unpacked decimal digits by dividing it by ten.

An execution stage drives both bytes, the incoming carry, auxiliary-carry and overflow flags, and the operation code, and pulses `start_i` for one cycle. The unit returns the corrected bytes and a full flag set (carry, auxiliary, parity, zero, sign, overflow) and pulses `done_o` for one cycle when they are valid. The results then hold until the next accepted operation.

The add and subtract corrections finish in a single cycle. The divide by ten is, by default, a restoring divider that retires one quotient bit per clock. A parameter selects a fully unrolled divider instead.

Top module: `dadj_unit`

## Requirements
- R1: While reset is active and after it is released, before any operation, `lo_o`, `hi_o`, every flag output and `done_o` are 0.
- R2: Operation code 2'b00 (unpacked add correction) with `lo_i[3:0]` greater than 9 or `af_i` set gives `lo_o = (lo_i + 6) & 8'h0F`, `hi_o = hi_i + 1` (wrapping at 8 bits), and `cf_o = af_o = 1`.
- R3: Operation code 2'b00 with `lo_i[3:0]` at most 9 and `af_i` clear gives `lo_o = lo_i & 8'h0F`, `hi_o = hi_i`, and `cf_o = af_o = 0`.
- R4: Operation code 2'b01 (packed subtract correction) subtracts 6 when `lo_i[3:0]` is greater than 9 or `af_i` is set. It then subtracts 8'h60 from that value when `lo_i` is greater than 8'h99 or `cf_i` is set, with every subtraction wrapping at 8 bits. `af_o` is 1 exactly when the first step was applied.
- R5: For operation code 2'b01, `cf_o` is 1 exactly when `lo_i > 8'h99` or `cf_i` is set, and `hi_o` equals `hi_i`.
- R6: For operation codes 2'b00 and 2'b01, `pf_o` is 1 when `lo_o` has an even number of ones, `zf_o` is 1 when `lo_o` is zero, `sf_o` equals `lo_o[7]`, and `of_o` equals `of_i`.
- R7: Operation code 2'b10 (divide by ten) gives `hi_o = lo_i / 10` and `lo_o = lo_i % 10`, with `cf_o = of_o = 0` and `af_o = af_i`. `zf_o` is 1 when both result bytes are zero, `sf_o = hi_o[7]`, and `pf_o` is the even parity of `lo_o`.
- R8: Operation code 2'b11 is a no-operation: `done_o` still pulses, and every data and flag output keeps its previous value.
- R9: With the default iterative divider, `done_o` is first seen high after 8 rising edges counted from the edge that samples `start_i` for operation code 2'b10, and after 1 edge for every other code.
- R10: `done_o` is high for exactly one cycle per accepted operation, and the outputs hold their values after it falls.
- R11: A `start_i` pulse that arrives while a divide is in progress is ignored: it neither changes the divide result nor produces an extra `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run the selected operation |
| op_i | input | 2 | Operation: 00 unpacked add correction, 01 packed subtract correction, 10 divide by ten, 11 no-op |
| lo_i | input | 8 | Low accumulator byte |
| hi_i | input | 8 | High accumulator byte |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| of_i | input | 1 | Incoming overflow flag |
| lo_o | output | 8 | Corrected low byte |
| hi_o | output | 8 | Corrected high byte |
| cf_o | output | 1 | Carry flag result |
| af_o | output | 1 | Auxiliary-carry flag result |
| pf_o | output | 1 | Parity flag result (even parity) |
| zf_o | output | 1 | Zero flag result |
| sf_o | output | 1 | Sign flag result |
| of_o | output | 1 | Overflow flag result |
| done_o | output | 1 | One-cycle pulse: results valid |

## Verification
The assertions assume that `start_i` is a clean single-cycle pulse, and that the operand inputs are stable in the cycle in which `start_i` is high. They do not assume the inputs stay stable after that, because the unit takes its copy at the accepting edge. The bench drives all inputs half a cycle away from the sampling edge and normally waits for `done_o` before issuing the next request. One directed case fires a deliberate second request in the middle of a divide, to show that the unit discards it. Random operands from a fixed seed cover all four operation codes, both carry-in values and both auxiliary-in values. Directed cases cover the nibble boundary at 9 and 10, the 8'h99 threshold, the high-byte wrap at 8'hFF, subtraction wrap below 6, and dividends of 0 and 255.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;

   typedef enum logic [1:0] {
      DADJ_ADD_UNP = 2'b00,
      DADJ_SUB_PKD = 2'b01,
      DADJ_DIV_TEN = 2'b10,
      DADJ_NOP     = 2'b11
   } dadj_op_e;

   typedef struct packed {
      logic [BYTE_W-1:0] lo;
      logic [BYTE_W-1:0] hi;
      logic              cf;
      logic              af;
   } dadj_res_t;

   // {parity(even), zero, sign} of a byte
   function automatic logic [2:0] byte_pzs(input logic [BYTE_W-1:0] v);
      return {~^v, (v == '0), v[BYTE_W-1]};
   endfunction

endpackage

// File: rtl/dadj_add_unp.sv
module dadj_add_unp
   import dadj_pkg::*;
#(
   parameter int unsigned DIGIT_MAX = 9,
   parameter int unsigned CORR      = 6
) (
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [BYTE_W-1:0] hi_i,
   input  logic              af_i,
   output dadj_res_t         res_o
);
   localparam logic [NIB_W-1:0]  LIMIT = NIB_W'(DIGIT_MAX);
   localparam logic [BYTE_W-1:0] ADDC  = BYTE_W'(CORR);
   localparam logic [BYTE_W-1:0] LOWM  = BYTE_W'((1 << NIB_W) - 1);

   initial begin
      if (CORR >= (1 << NIB_W) || DIGIT_MAX >= (1 << NIB_W))
         $error("dadj_add_unp: correction constants exceed a nibble");
   end

   logic fix;
   logic [BYTE_W-1:0] sum;

   always_comb begin
      fix = (lo_i[NIB_W-1:0] > LIMIT) || af_i;
      sum = lo_i + ADDC;
      if (fix) begin
         res_o.lo = sum & LOWM;
         res_o.hi = hi_i + 1'b1;
         res_o.cf = 1'b1;
         res_o.af = 1'b1;
      end else begin
         res_o.lo = lo_i & LOWM;
         res_o.hi = hi_i;
         res_o.cf = 1'b0;
         res_o.af = 1'b0;
      end
   end
endmodule

// File: rtl/dadj_sub_pkd.sv
module dadj_sub_pkd
   import dadj_pkg::*;
#(
   parameter int unsigned DIGIT_MAX = 9,
   parameter int unsigned CORR      = 6
) (
   input  logic [BYTE_W-1:0] lo_i,
   input  logic              cf_i,
   input  logic              af_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic              cf_o,
   output logic              af_o
);
   localparam logic [NIB_W-1:0]  LIMIT    = NIB_W'(DIGIT_MAX);
   localparam logic [BYTE_W-1:0] LO_CORR  = BYTE_W'(CORR);
   localparam logic [BYTE_W-1:0] HI_CORR  = BYTE_W'(CORR << NIB_W);
   localparam logic [BYTE_W-1:0] HI_LIMIT = BYTE_W'((DIGIT_MAX << NIB_W) | DIGIT_MAX);

   logic fix_lo, fix_hi;
   logic [BYTE_W-1:0] step1;

   always_comb begin
      fix_lo = (lo_i[NIB_W-1:0] > LIMIT) || af_i;
      step1  = fix_lo ? (lo_i - LO_CORR) : lo_i;
      // the high step decides the final carry on both of its paths, so a
      // borrow out of the low step never reaches the output
      fix_hi = (lo_i > HI_LIMIT) || cf_i;
      lo_o   = fix_hi ? (step1 - HI_CORR) : step1;
      cf_o   = fix_hi;
      af_o   = fix_lo;
   end
endmodule

// File: rtl/dadj_div.sv
module dadj_div #(
   parameter int unsigned W       = 8,
   parameter int unsigned DIVISOR = 10,
   parameter bit          ITER    = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         go_i,
   input  logic [W-1:0]                 num_i,
   output logic                         last_o,
   output logic [W-1:0]                 quo_o,
   output logic [$clog2(DIVISOR)-1:0]   rem_o
);
   localparam int unsigned REM_W = $clog2(DIVISOR);
   localparam int unsigned TRY_W = REM_W + 1;
   localparam int unsigned ACC_W = REM_W + W;
   localparam int unsigned CNT_W = $clog2(W);
   localparam logic [TRY_W-1:0] DVS = TRY_W'(DIVISOR);

   initial begin
      if (W < 2) $error("dadj_div: W must be at least 2");
      if (DIVISOR < 2 || DIVISOR >= (1 << W)) $error("dadj_div: DIVISOR out of range");
   end

   // one restoring step: acc = {remainder, remaining dividend / quotient}
   function automatic logic [ACC_W-1:0] div_step(input logic [ACC_W-1:0] acc);
      logic [TRY_W-1:0] trial;
      logic [REM_W-1:0] left;
      trial = {acc[ACC_W-1:W], acc[W-1]};
      if (trial >= DVS) begin
         left = REM_W'(trial - DVS);
         return {left, acc[W-2:0], 1'b1};
      end else begin
         left = trial[REM_W-1:0];
         return {left, acc[W-2:0], 1'b0};
      end
   endfunction

   generate
      if (ITER) begin : g_iter
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] acc_nxt;
         logic [CNT_W-1:0] left_q;

         assign acc_nxt = div_step(acc_q);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q  <= '0;
               left_q <= '0;
            end else if (go_i) begin
               acc_q  <= div_step({REM_W'(0), num_i});
               left_q <= CNT_W'(W - 1);
            end else if (left_q != '0) begin
               acc_q  <= acc_nxt;
               left_q <= left_q - 1'b1;
            end
         end

         assign last_o = (left_q == CNT_W'(1));
         assign quo_o  = acc_nxt[W-1:0];
         assign rem_o  = acc_nxt[ACC_W-1:W];
      end else begin : g_comb
         logic [ACC_W-1:0] chain [W+1];
         assign chain[0] = {REM_W'(0), num_i};
         for (genvar s = 0; s < W; s++) begin : g_stage
            assign chain[s+1] = div_step(chain[s]);
         end
         assign last_o = go_i;
         assign quo_o  = chain[W][W-1:0];
         assign rem_o  = chain[W][ACC_W-1:W];
      end
   endgenerate
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
   import dadj_pkg::*;
#(
   parameter int unsigned DIVISOR  = 10,
   parameter bit          DIV_ITER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [BYTE_W-1:0] hi_i,
   input  logic              cf_i,
   input  logic              af_i,
   input  logic              of_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o,
   output logic              cf_o,
   output logic              af_o,
   output logic              pf_o,
   output logic              zf_o,
   output logic              sf_o,
   output logic              of_o,
   output logic              done_o
);
   localparam int unsigned REM_W = $clog2(DIVISOR);

   initial begin
      if (REM_W > BYTE_W) $error("dadj_unit: remainder wider than a byte");
   end

   dadj_res_t         add_res;
   logic [BYTE_W-1:0] sub_lo;
   logic              sub_cf, sub_af;
   logic              div_last;
   logic [BYTE_W-1:0] div_quo;
   logic [REM_W-1:0]  div_rem;
   logic [BYTE_W-1:0] div_lo;
   logic              busy_q;
   logic              accept;
   logic              div_go;
   dadj_op_e          op;

   assign op     = dadj_op_e'(op_i);
   assign accept = start_i && !busy_q;
   assign div_go = accept && (op == DADJ_DIV_TEN);
   assign div_lo = BYTE_W'(div_rem);

   dadj_add_unp u_add (
      .lo_i (lo_i),
      .hi_i (hi_i),
      .af_i (af_i),
      .res_o(add_res)
   );

   dadj_sub_pkd u_sub (
      .lo_i(lo_i),
      .cf_i(cf_i),
      .af_i(af_i),
      .lo_o(sub_lo),
      .cf_o(sub_cf),
      .af_o(sub_af)
   );

   dadj_div #(
      .W      (BYTE_W),
      .DIVISOR(DIVISOR),
      .ITER   (DIV_ITER)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (div_go),
      .num_i (lo_i),
      .last_o(div_last),
      .quo_o (div_quo),
      .rem_o (div_rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_o   <= '0;
         hi_o   <= '0;
         cf_o   <= 1'b0;
         af_o   <= 1'b0;
         pf_o   <= 1'b0;
         zf_o   <= 1'b0;
         sf_o   <= 1'b0;
         of_o   <= 1'b0;
         done_o <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept) begin
            unique case (op)
               DADJ_ADD_UNP: begin
                  lo_o <= add_res.lo;
                  hi_o <= add_res.hi;
                  cf_o <= add_res.cf;
                  af_o <= add_res.af;
                  {pf_o, zf_o, sf_o} <= byte_pzs(add_res.lo);
                  of_o   <= of_i;
                  done_o <= 1'b1;
               end
               DADJ_SUB_PKD: begin
                  lo_o <= sub_lo;
                  hi_o <= hi_i;
                  cf_o <= sub_cf;
                  af_o <= sub_af;
                  {pf_o, zf_o, sf_o} <= byte_pzs(sub_lo);
                  of_o   <= of_i;
                  done_o <= 1'b1;
               end
               DADJ_DIV_TEN: begin
                  af_o   <= af_i;
                  busy_q <= 1'b1;
               end
               default: begin
                  done_o <= 1'b1;
               end
            endcase
         end
         // in the unrolled variant this fires on the accepting edge itself
         if (div_last) begin
            lo_o   <= div_lo;
            hi_o   <= div_quo;
            cf_o   <= 1'b0;
            of_o   <= 1'b0;
            pf_o   <= ~^div_lo;
            zf_o   <= (div_lo == '0) && (div_quo == '0);
            sf_o   <= div_quo[BYTE_W-1];
            busy_q <= 1'b0;
            done_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dadj_unit_chk.sv
module dadj_unit_chk
   import dadj_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic [1:0]  op_i,
   input logic [7:0]  lo_i,
   input logic        cf_i,
   input logic        of_i,
   input logic        busy,
   input logic [7:0]  lo_o,
   input logic [7:0]  hi_o,
   input logic        cf_o,
   input logic        af_o,
   input logic        pf_o,
   input logic        zf_o,
   input logic        sf_o,
   input logic        of_o,
   input logic        done_o
);
   logic       acc;
   logic [1:0] last_op_q;

   assign acc = start_i && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n)   last_op_q <= 2'b00;
      else if (acc) last_op_q <= op_i;
   end

   // R2, R3: unpacked add leaves only a digit and ties carry to auxiliary
   a_r2_add_digit: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i == 2'b00 |=> lo_o[7:4] == 4'h0 && cf_o == af_o);

   // R5: packed subtract carry rule
   a_r5_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_i == 2'b01 |=> cf_o == ($past(lo_i) > 8'h99 || $past(cf_i)));

   // R6: flags track the corrected byte for add and subtract
   a_r6_byte_flags: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !op_i[1] |=> zf_o == (lo_o == 8'h00) && sf_o == lo_o[7]
                          && pf_o == ~^lo_o && of_o == $past(of_i));

   // R7: divide result is a digit with carry and overflow cleared
   a_r7_div_digit: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && last_op_q == 2'b10 |-> lo_o < 8'd10 && !cf_o && !of_o
                                       && zf_o == (lo_o == 8'h00 && hi_o == 8'h00));

   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !acc |=> !done_o);

   // R11: nothing completes or moves while a divide is in flight
   a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done_o);

   a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(lo_o) && $stable(hi_o));
endmodule

bind dadj_unit dadj_unit_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .op_i   (op_i),
   .lo_i   (lo_i),
   .cf_i   (cf_i),
   .of_i   (of_i),
   .busy   (busy_q),
   .lo_o   (lo_o),
   .hi_o   (hi_o),
   .cf_o   (cf_o),
   .af_o   (af_o),
   .pf_o   (pf_o),
   .zf_o   (zf_o),
   .sf_o   (sf_o),
   .of_o   (of_o),
   .done_o (done_o)
);

// File: tb/dadj_unit_tb.sv
module dadj_unit_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] op_i = 2'b00;
   logic [7:0] lo_i = 8'h00, hi_i = 8'h00;
   logic       cf_i = 1'b0, af_i = 1'b0, of_i = 1'b0;
   logic [7:0] lo_o, hi_o;
   logic       cf_o, af_o, pf_o, zf_o, sf_o, of_o, done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // expected output state
   logic [7:0] e_lo = 8'h00, e_hi = 8'h00;
   logic       e_cf = 0, e_af = 0, e_pf = 0, e_zf = 0, e_sf = 0, e_of = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dadj_unit #(.DIVISOR(10), .DIV_ITER(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .lo_i(lo_i), .hi_i(hi_i), .cf_i(cf_i), .af_i(af_i), .of_i(of_i),
      .lo_o(lo_o), .hi_o(hi_o), .cf_o(cf_o), .af_o(af_o), .pf_o(pf_o),
      .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .done_o(done_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // expected behaviour, written from the requirements
   task automatic model(input logic [1:0] op, input logic [7:0] lo, hi,
                        input logic cf, af, of);
      logic fl, fh;
      logic [7:0] t;
      case (op)
         2'b00: begin
            if (lo[3:0] > 4'd9 || af) begin
               e_lo = (lo + 8'd6) & 8'h0F; e_hi = hi + 8'd1; e_cf = 1; e_af = 1;
            end else begin
               e_lo = lo & 8'h0F; e_hi = hi; e_cf = 0; e_af = 0;
            end
            e_of = of;
         end
         2'b01: begin
            fl = (lo[3:0] > 4'd9) || af;
            t  = fl ? lo - 8'd6 : lo;
            fh = (lo > 8'h99) || cf;
            e_lo = fh ? t - 8'h60 : t;
            e_hi = hi; e_cf = fh; e_af = fl; e_of = of;
         end
         2'b10: begin
            e_hi = lo / 8'd10; e_lo = lo % 8'd10;
            e_cf = 0; e_of = 0; e_af = af;
            e_zf = (e_lo == 0) && (e_hi == 0);
            e_sf = e_hi[7];
            e_pf = ~^e_lo;
         end
         default: ;
      endcase
      if (op[1] == 1'b0) begin
         e_pf = ~^e_lo; e_zf = (e_lo == 0); e_sf = e_lo[7];
      end
   endtask

   task automatic compare(input string req);
      chk(req, "lo", lo_o, e_lo);
      chk(req, "hi", hi_o, e_hi);
      chk(req, "cf", cf_o, e_cf);
      chk(req, "af", af_o, e_af);
      chk(req, "pf", pf_o, e_pf);
      chk(req, "zf", zf_o, e_zf);
      chk(req, "sf", sf_o, e_sf);
      chk(req, "of", of_o, e_of);
   endtask

   task automatic run_op(input logic [1:0] op, input logic [7:0] lo, hi,
                         input logic cf, af, of, input string req);
      int n;
      @(negedge clk);
      op_i = op; lo_i = lo; hi_i = hi; cf_i = cf; af_i = af; of_i = of; start_i = 1;
      @(negedge clk);
      start_i = 0;
      n = 1;
      while (!done_o && n < 20) begin
         @(negedge clk);
         n++;
      end
      model(op, lo, hi, cf, af, of);
      chk("R9", "latency", n, (op == 2'b10) ? 8 : 1);
      compare(req);
      @(negedge clk);
      chk("R10", "done falls", done_o, 0);
      compare("R10");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: state under reset and just after release
      compare("R1");
      chk("R1", "done", done_o, 0);
      rst_n = 1;
      @(negedge clk);
      compare("R1");
      chk("R1", "done", done_o, 0);

      // R2: nibble above 9, aux set, high byte wrap
      run_op(2'b00, 8'h0A, 8'h05, 0, 0, 1, "R2");
      run_op(2'b00, 8'h33, 8'h10, 0, 1, 0, "R2");
      run_op(2'b00, 8'hFF, 8'hFF, 1, 0, 0, "R2");
      // R3: boundary at 9, no correction
      run_op(2'b00, 8'h39, 8'h07, 1, 0, 0, "R3");
      run_op(2'b00, 8'hF0, 8'h00, 0, 0, 1, "R3");
      // R4 / R5: packed subtract cases
      run_op(2'b01, 8'h9A, 8'h11, 0, 0, 0, "R4");
      run_op(2'b01, 8'h05, 8'h22, 0, 1, 0, "R4");
      run_op(2'b01, 8'h99, 8'h33, 0, 0, 1, "R5");
      run_op(2'b01, 8'h12, 8'h44, 1, 0, 0, "R5");
      // R6: zero and sign results
      run_op(2'b01, 8'h66, 8'h00, 1, 1, 1, "R6");
      run_op(2'b00, 8'h80, 8'h00, 0, 0, 0, "R6");
      // R7: divide extremes
      run_op(2'b10, 8'hFF, 8'h77, 1, 1, 1, "R7");
      run_op(2'b10, 8'h00, 8'h12, 1, 0, 1, "R7");
      run_op(2'b10, 8'h0A, 8'h00, 0, 1, 0, "R7");
      // R8: no-op keeps everything
      run_op(2'b11, 8'h5A, 8'hA5, 1, 1, 1, "R8");

      // R11: a second request in the middle of a divide is dropped
      begin
         int n;
         @(negedge clk);
         op_i = 2'b10; lo_i = 8'h63; hi_i = 8'h00; cf_i = 1; af_i = 0; of_i = 1; start_i = 1;
         @(negedge clk);
         start_i = 0;
         @(negedge clk);
         op_i = 2'b00; lo_i = 8'h0A; hi_i = 8'h40; af_i = 1; start_i = 1;
         @(negedge clk);
         start_i = 0;
         n = 3;
         while (!done_o && n < 20) begin
            @(negedge clk);
            n++;
         end
         model(2'b10, 8'h63, 8'h00, 1, 0, 1);
         chk("R11", "latency", n, 8);
         compare("R11");
         @(negedge clk);
         chk("R11", "no extra done", done_o, 0);
         @(negedge clk);
         chk("R11", "no extra done", done_o, 0);
         compare("R11");
      end

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [1:0] op;
         string req;
         op = 2'($urandom_range(0, 3));
         case (op)
            2'b00: req = "R2/R3 rnd";
            2'b01: req = "R4/R5 rnd";
            2'b10: req = "R7 rnd";
            default: req = "R8 rnd";
         endcase
         run_op(op, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), req);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule